// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a core that runs in several operating modes. A 5-bit mode code picks one of eight banks: user, fast interrupt, interrupt, supervisor, abort, undefined, system, and a catch-all dummy bank for codes that name no real mode. The live registers are what the core reads and writes. Registers 0 to 7 and 15 are shared by every mode. The fast-interrupt bank keeps its own copies of registers 8 to 14. Every other bank keeps its own copies of registers 13 and 14 only. Registers 8 to 12 of all the non-fast banks are one shared set.

A mode change is requested with `mode_wr` and `mode_in` and takes effect at the next clock edge. On that edge the block copies the outgoing bank's private registers out of the live set and copies the incoming bank's registers in. The state register is the current mode. Its derived state is the current bank (`BK_USR`, `BK_FIQ`, `BK_IRQ`, `BK_SVC`, `BK_ABT`, `BK_UND`, `BK_SYS`, `BK_DMY`). Each mode request is classed as one of these transitions:
- `XF_SAME`: the bank does not change and nothing is copied.
- `XF_ENTER`: the fast-interrupt bank is entered.
- `XF_LEAVE`: the fast-interrupt bank is left.
- `XF_SWAP`: the switch is between two non-fast banks.

If no request is made the transition is `XF_NONE`.

A side port reads or writes any register as another mode sees it. A status port keeps one saved status word per bank. The block also drives a privileged-access flag and reports the current bank.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode is 19 (supervisor bank, code 3). All live and banked registers read zero, and all saved status words read zero.
- R2: The bank code (`bank_o`) is mapped from the mode as follows. Modes 0/16 give 0 (user), 1/17 give 1 (fast), 2/18 give 2 (interrupt) and 3/19 give 3 (supervisor). Mode 23 gives 4 (abort), 27 gives 5 (undefined) and 31 gives 6 (system). Every other code gives 7 (dummy).
- R3: `priv` is high exactly when bit 1 or bit 0 of the current mode is 1.
- R4: A mode change that keeps the same bank copies nothing, so the live registers keep their values.
- R5: Entering the fast bank from another bank does three things. Live r8–r12 are saved as the shared set. Live r13–r14 are saved into the old bank. r8–r14 are then loaded from the fast bank.
- R6: Leaving the fast bank does three things. Live r8–r14 are saved into the fast bank. r8–r12 are restored from the shared set. r13–r14 are loaded from the new bank.
- R7: A switch between two different non-fast banks saves and loads only r13 and r14.
- R8: Saving into the dummy bank stores zero, so its r13/r14 always load as zero. A side-port write that names a dummy-bank mode while the core is in another bank is ignored.
- R9: A side-port access whose mode maps to the current bank goes to the live register, as do r0–r7 and r15. Otherwise r8–r14 go to that bank's storage. A non-fast bank's r8–r12 are the live ones unless the core is in the fast bank.
- R10: In a cycle with `mode_wr` high, core and side-port register writes are ignored. Side-port reads in that cycle use the mapping from before the switch.
- R11: Each bank has a saved status word, written with `ss_we` and read combinationally on `ss_rdata`. For the user and system banks, a read returns `cpsr_in` and a write is ignored.
- R12: The core port reads the live register combinationally and writes it at the clock edge. If the core and the side port write the same live register in the same cycle, the core wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Request a mode change |
| mode_in | input | 5 | Requested mode |
| cpsr_in | input | DW | Current status word |
| rd_addr | input | 4 | Core read register |
| rd_data | output | DW | Core read data |
| wr_en | input | 1 | Core write enable |
| wr_addr | input | 4 | Core write register |
| wr_data | input | DW | Core write data |
| sp_mode | input | 5 | Side-port mode |
| sp_addr | input | 4 | Side-port register |
| sp_we | input | 1 | Side-port write enable |
| sp_wdata | input | DW | Side-port write data |
| sp_rdata | output | DW | Side-port read data |
| ss_mode | input | 5 | Saved-status mode |
| ss_we | input | 1 | Saved-status write enable |
| ss_wdata | input | DW | Saved-status write data |
| ss_rdata | output | DW | Saved-status read data |
| cur_mode | output | 5 | Current mode |
| bank_o | output | 3 | Current bank code |
| priv | output | 1 | Privileged-access flag |

## Verification
The bench builds the block with DW = 8. With that width, each register can carry a tag that encodes both its bank and its index, so any value that is mis-routed can be identified. This makes three sweeps affordable. The first covers all 32 mode codes for the mapping and the privilege flag. The second covers every ordered pair of the seven real modes, followed by a read of all sixteen live registers and of r8–r14 through the side port for each mode. The third covers every bank's saved status slot.

// File: rtl/brf_pkg.sv
package brf_pkg;
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5,
        BK_SYS = 3'd6,
        BK_DMY = 3'd7
    } bank_e;

    typedef enum logic [2:0] {
        XF_NONE,
        XF_SAME,
        XF_ENTER,
        XF_LEAVE,
        XF_SWAP
    } xfer_e;

    typedef enum logic [2:0] {
        T_LIVE,
        T_USRHI,
        T_FIQHI,
        T_SH13,
        T_SH14
    } tgt_e;

    localparam int          NBANK      = 8;
    localparam int          NREG       = 16;
    localparam int          NHI        = 5;
    localparam logic [4:0]  RESET_MODE = 5'd19;
endpackage

// File: rtl/brf_bank_map.sv
module brf_bank_map
    import brf_pkg::*;
(
    input  logic [4:0] mode,
    output bank_e      bank
);
    always_comb begin
        if (mode[4:2] == 3'b000 || mode[4:2] == 3'b100) begin
            bank = bank_e'({1'b0, mode[1:0]});
        end else begin
            unique case (mode)
                5'd23:   bank = BK_ABT;
                5'd27:   bank = BK_UND;
                5'd31:   bank = BK_SYS;
                default: bank = BK_DMY;
            endcase
        end
    end
endmodule

// File: rtl/brf_spsr_store.sv
module brf_spsr_store
    import brf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         ss_bank,
    input  logic          ss_we,
    input  logic [DW-1:0] ss_wdata,
    input  logic [DW-1:0] cpsr_in,
    output logic [DW-1:0] ss_rdata
);
    logic [DW-1:0] slot_q [NBANK];
    logic          no_slot;

    assign no_slot  = (ss_bank == BK_USR) || (ss_bank == BK_SYS);
    assign ss_rdata = no_slot ? cpsr_in : slot_q[ss_bank];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBANK; i++) slot_q[i] <= '0;
        end else if (ss_we && !no_slot) begin
            slot_q[ss_bank] <= ss_wdata;
        end
    end

    // R11: a write to a bank that owns a slot is held there
    a_r11_slot_store: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_we && ss_bank != BK_USR && ss_bank != BK_SYS)
        |=> slot_q[$past(ss_bank)] == $past(ss_wdata));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [4:0]    mode_in,
    input  logic [DW-1:0] cpsr_in,
    input  logic [3:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [4:0]    sp_mode,
    input  logic [3:0]    sp_addr,
    input  logic          sp_we,
    input  logic [DW-1:0] sp_wdata,
    output logic [DW-1:0] sp_rdata,
    input  logic [4:0]    ss_mode,
    input  logic          ss_we,
    input  logic [DW-1:0] ss_wdata,
    output logic [DW-1:0] ss_rdata,
    output logic [4:0]    cur_mode,
    output logic [2:0]    bank_o,
    output logic          priv
);
    localparam int NMAP   = 3;
    localparam int HI_BASE = 8;

    // state register: current mode and its bank
    logic [4:0]    mode_q;
    bank_e         cur_bank;

    logic [DW-1:0] live_q [NREG];
    logic [DW-1:0] usr_hi [NHI];
    logic [DW-1:0] fiq_hi [NHI];
    logic [DW-1:0] sh13_q [NBANK];
    logic [DW-1:0] sh14_q [NBANK];

    // bank decoders for requested, side-port and status modes
    logic [4:0] map_mode [NMAP];
    bank_e      map_bank [NMAP];
    assign map_mode[0] = mode_in;
    assign map_mode[1] = sp_mode;
    assign map_mode[2] = ss_mode;

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        brf_bank_map u_map (.mode(map_mode[g]), .bank(map_bank[g]));
    end

    bank_e new_bank, sp_bank, ss_bank;
    assign new_bank = map_bank[0];
    assign sp_bank  = map_bank[1];
    assign ss_bank  = map_bank[2];

    // transition class
    xfer_e xfer;
    always_comb begin
        if (!mode_wr)                  xfer = XF_NONE;
        else if (new_bank == cur_bank) xfer = XF_SAME;
        else if (new_bank == BK_FIQ)   xfer = XF_ENTER;
        else if (cur_bank == BK_FIQ)   xfer = XF_LEAVE;
        else                           xfer = XF_SWAP;
    end

    // side-port target
    tgt_e          sp_tgt;
    logic [2:0]    hi_idx;
    logic          sp_wr_ok;
    always_comb begin
        hi_idx = 3'(sp_addr - 4'(HI_BASE));
        if (sp_bank == cur_bank || sp_addr < 4'(HI_BASE) || sp_addr == 4'd15)
            sp_tgt = T_LIVE;
        else if (sp_addr <= 4'd12)
            sp_tgt = (sp_bank == BK_FIQ) ? T_FIQHI
                   : ((cur_bank == BK_FIQ) ? T_USRHI : T_LIVE);
        else if (sp_addr == 4'd13)
            sp_tgt = T_SH13;
        else
            sp_tgt = T_SH14;
    end

    assign sp_wr_ok = sp_we && !mode_wr && !(sp_bank == BK_DMY && cur_bank != BK_DMY);

    always_comb begin
        unique case (sp_tgt)
            T_USRHI: sp_rdata = usr_hi[hi_idx];
            T_FIQHI: sp_rdata = fiq_hi[hi_idx];
            T_SH13:  sp_rdata = sh13_q[sp_bank];
            T_SH14:  sp_rdata = sh14_q[sp_bank];
            default: sp_rdata = live_q[sp_addr];
        endcase
    end

    assign rd_data  = live_q[rd_addr];
    assign cur_mode = mode_q;
    assign bank_o   = cur_bank;
    assign priv     = |mode_q[1:0];

    // state and register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= RESET_MODE;
            cur_bank <= BK_SVC;
            for (int i = 0; i < NREG; i++)  live_q[i] <= '0;
            for (int i = 0; i < NHI; i++) begin
                usr_hi[i] <= '0;
                fiq_hi[i] <= '0;
            end
            for (int i = 0; i < NBANK; i++) begin
                sh13_q[i] <= '0;
                sh14_q[i] <= '0;
            end
        end else begin
            unique case (xfer)
                XF_NONE: begin
                    if (sp_wr_ok) begin
                        unique case (sp_tgt)
                            T_USRHI: usr_hi[hi_idx]  <= sp_wdata;
                            T_FIQHI: fiq_hi[hi_idx]  <= sp_wdata;
                            T_SH13:  sh13_q[sp_bank] <= sp_wdata;
                            T_SH14:  sh14_q[sp_bank] <= sp_wdata;
                            default: live_q[sp_addr] <= sp_wdata;
                        endcase
                    end
                    if (wr_en) live_q[wr_addr] <= wr_data;
                end
                XF_SAME: begin
                    mode_q <= mode_in;
                end
                default: begin
                    mode_q   <= mode_in;
                    cur_bank <= new_bank;
                    for (int i = 0; i < NHI; i++) begin
                        if (xfer == XF_ENTER) begin
                            usr_hi[i]           <= live_q[HI_BASE+i];
                            live_q[HI_BASE+i]   <= fiq_hi[i];
                        end else if (xfer == XF_LEAVE) begin
                            fiq_hi[i]           <= live_q[HI_BASE+i];
                            live_q[HI_BASE+i]   <= usr_hi[i];
                        end
                    end
                    sh13_q[cur_bank] <= (cur_bank == BK_DMY) ? '0 : live_q[13];
                    sh14_q[cur_bank] <= (cur_bank == BK_DMY) ? '0 : live_q[14];
                    live_q[13]       <= sh13_q[new_bank];
                    live_q[14]       <= sh14_q[new_bank];
                end
            endcase
        end
    end

    brf_spsr_store #(.DW(DW)) u_spsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_bank  (ss_bank),
        .ss_we    (ss_we),
        .ss_wdata (ss_wdata),
        .cpsr_in  (cpsr_in),
        .ss_rdata (ss_rdata)
    );

    // R3: the user bank is never privileged
    a_r3_user_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_o == 3'(BK_USR)) |-> !priv);

    // R4: same-bank change leaves the banked live registers alone
    a_r4_same_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && new_bank == cur_bank)
        |=> $stable(live_q[13]) && $stable(live_q[8]));

    // R5: entering the fast bank saves the shared set and loads the fast copies
    a_r5_enter_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && new_bank == BK_FIQ && cur_bank != BK_FIQ)
        |=> live_q[8] == $past(fiq_hi[0]) && usr_hi[4] == $past(live_q[12]));

    // R6: leaving the fast bank saves its copies and restores the shared set
    a_r6_leave_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && cur_bank == BK_FIQ && new_bank != BK_FIQ)
        |=> live_q[12] == $past(usr_hi[4]) && fiq_hi[0] == $past(live_q[8]));

    // R7: any bank change loads r13 from the new bank's store
    a_r7_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && new_bank != cur_bank)
        |=> live_q[13] == $past(sh13_q[new_bank]));

    // R10: no register write lands on a switch cycle outside the copy
    a_r10_sw_block: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wr_en && wr_addr < 4'd8) |=> $stable(live_q[0]) && $stable(live_q[7]));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic [4:0]    mode_in = '0;
    logic [DW-1:0] cpsr_in = '0;
    logic [3:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [4:0]    sp_mode = '0;
    logic [3:0]    sp_addr = '0;
    logic          sp_we = 1'b0;
    logic [DW-1:0] sp_wdata = '0;
    logic [DW-1:0] sp_rdata;
    logic [4:0]    ss_mode = '0;
    logic          ss_we = 1'b0;
    logic [DW-1:0] ss_wdata = '0;
    logic [DW-1:0] ss_rdata;
    logic [4:0]    cur_mode;
    logic [2:0]    bank_o;
    logic          priv;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    banked_regfile #(.DW(DW)) u0 (.*);

    int modes [7] = '{16, 17, 18, 19, 23, 27, 31};

    function automatic int bank_of(input int m);
        if (m % 16 < 4 && m < 20) return m % 4;
        if (m == 23) return 4;
        if (m == 27) return 5;
        if (m == 31) return 6;
        return 7;
    endfunction

    function automatic logic [7:0] tag(input int b, input int r);
        return 8'(((b + 1) << 4) | r);
    endfunction

    function automatic logic [7:0] exp_reg(input int b, input int r);
        if (r < 8 || r == 15) return 8'(8'hC0 | r);
        if (r <= 12)          return (b == 1) ? tag(1, r) : tag(6, r);
        return tag(b, r);
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
        mode_wr = 0; wr_en = 0; sp_we = 0; ss_we = 0;
    endtask

    task automatic go_mode(input int m);
        @(negedge clk); mode_wr = 1; mode_in = 5'(m); cycle();
    endtask

    task automatic core_wr(input int a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = d; cycle();
    endtask

    task automatic side_wr(input int m, input int a, input logic [7:0] d);
        @(negedge clk); sp_we = 1; sp_mode = 5'(m); sp_addr = 4'(a); sp_wdata = d; cycle();
    endtask

    task automatic ss_wr(input int m, input logic [7:0] d);
        @(negedge clk); ss_we = 1; ss_mode = 5'(m); ss_wdata = d; cycle();
    endtask

    task automatic core_rd(input int a, output logic [7:0] v);
        rd_addr = 4'(a); #1; v = rd_data;
    endtask

    task automatic side_rd(input int m, input int a, output logic [7:0] v);
        sp_mode = 5'(m); sp_addr = 4'(a); #1; v = sp_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        for (int r = 0; r < 16; r++) begin
            core_rd(r, v); chk("R1 reg", v, 8'h00);
        end
        chk("R1 mode", 8'(cur_mode), 8'd19);
        chk("R1 bank", 8'(bank_o), 8'd3);
        ss_mode = 5'd18; #1; chk("R1 saved status", ss_rdata, 8'h00);

        // R2 and R3 over every mode code
        for (int m = 0; m < 32; m++) begin
            go_mode(m);
            chk("R2 bank map", 8'(bank_o), 8'(bank_of(m)));
            chk("R3 priv", 8'(priv), 8'((m % 4) != 0));
        end

        // seed unbanked and banked registers
        go_mode(19);
        for (int r = 0; r < 8; r++) core_wr(r, 8'(8'hC0 | r));
        core_wr(15, 8'hCF);
        foreach (modes[k]) begin
            go_mode(modes[k]);
            for (int r = 8; r < 15; r++) core_wr(r, tag(bank_of(modes[k]), r));
        end

        // R5/R6/R7/R9 over every ordered pair of real modes
        foreach (modes[i]) begin
            foreach (modes[j]) begin
                go_mode(modes[i]);
                go_mode(modes[j]);
                for (int r = 0; r < 16; r++) begin
                    core_rd(r, v);
                    chk("R5/R6/R7 live", v, exp_reg(bank_of(modes[j]), r));
                end
                foreach (modes[k]) begin
                    for (int r = 8; r < 15; r++) begin
                        side_rd(modes[k], r, v);
                        chk("R9 side read", v, exp_reg(bank_of(modes[k]), r));
                    end
                end
            end
        end
        go_mode(1);
        core_rd(13, v); chk("R2 alias fast", v, tag(1, 13));

        // R4 same-bank change
        go_mode(19);
        core_wr(13, 8'h77);
        go_mode(3);
        core_rd(13, v); chk("R4 same bank keep", v, 8'h77);
        core_wr(13, 8'h78);
        go_mode(19);
        core_rd(13, v); chk("R4 same bank back", v, 8'h78);

        // R8 dummy bank
        go_mode(5);
        core_rd(13, v); chk("R8 dummy load", v, 8'h00);
        core_wr(13, 8'hAA);
        go_mode(19);
        core_rd(13, v); chk("R8 back to svc", v, 8'h78);
        go_mode(5);
        core_rd(13, v); chk("R8 dummy saved zero", v, 8'h00);
        go_mode(19);
        side_wr(5, 13, 8'h55);
        side_rd(5, 13, v); chk("R8 dummy side write", v, 8'h00);

        // R9 side writes to other banks
        side_wr(18, 13, 8'h3C);
        side_rd(18, 13, v); chk("R9 side rd back", v, 8'h3C);
        go_mode(18);
        core_rd(13, v); chk("R9 side wr irq", v, 8'h3C);
        side_wr(17, 9, 8'h4D);
        go_mode(17);
        core_rd(9, v); chk("R9 side wr fast", v, 8'h4D);
        side_wr(16, 10, 8'h5E);
        go_mode(16);
        core_rd(10, v); chk("R9 side wr shared", v, 8'h5E);

        // R10 writes blocked on a switch cycle, side read uses old mapping
        @(negedge clk);
        mode_wr = 1; mode_in = 5'd16;
        wr_en = 1; wr_addr = 4'd0; wr_data = 8'h99;
        sp_we = 1; sp_mode = 5'd16; sp_addr = 4'd1; sp_wdata = 8'h98;
        cycle();
        core_rd(0, v); chk("R10 core write blocked", v, 8'hC0);
        core_rd(1, v); chk("R10 side write blocked", v, 8'hC1);
        @(negedge clk);
        mode_wr = 1; mode_in = 5'd17; sp_mode = 5'd16; sp_addr = 4'd13;
        #1; chk("R10 pre-switch side read", sp_rdata, tag(0, 13));
        cycle();
        core_rd(13, v); chk("R10 switch done", v, tag(1, 13));

        // R12 core port and write priority
        core_wr(3, 8'h33);
        core_rd(3, v); chk("R12 core write", v, 8'h33);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'd4; wr_data = 8'h44;
        sp_we = 1; sp_mode = 5'd17; sp_addr = 4'd4; sp_wdata = 8'h45;
        cycle();
        core_rd(4, v); chk("R12 core wins", v, 8'h44);

        // R11 saved status
        cpsr_in = 8'hE5;
        foreach (modes[k]) ss_wr(modes[k], 8'(8'h10 + k));
        foreach (modes[k]) begin
            ss_mode = 5'(modes[k]); #1;
            if (bank_of(modes[k]) == 0 || bank_of(modes[k]) == 6)
                chk("R11 user/system read", ss_rdata, 8'hE5);
            else
                chk("R11 saved slot", ss_rdata, 8'(8'h10 + k));
        end
        cpsr_in = 8'h1A;
        ss_mode = 5'd16; #1; chk("R11 follows status", ss_rdata, 8'h1A);
        ss_mode = 5'd18; #1; chk("R11 irq kept", ss_rdata, 8'h12);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule